// File: doc/BRIEF.md
# NAND Bank Access Sequencer

This block connects a simple processor-side bus to a single NAND flash bank. Two kinds of access are accepted. Register accesses reach a small file of four 32-bit registers: a control word, a read-only status word and two packed phase-timing words. Window accesses are turned into one bus cycle on the flash pins. Two bits of the window address decide whether that cycle latches a command, latches an address or moves data. Writes send bytes or half-words out, and reads return the word sampled from the flash.

Every flash cycle passes through four timed phases: setup, strobe, hold and bus release. The length of each phase in clocks comes from one byte of a timing word. Writes use the write-timing word and reads use the read-timing word. A read data cycle that directly follows a command or address cycle can first wait a programmable number of clocks. When ready/busy waiting is enabled, a cycle does not start while the flash reports busy. Chip enable follows the bank-enable bit, and a soft-reset bit holds the bank inactive.

The sequencer's states and transitions are as follows. IDLE goes to RBWAIT when a cycle is requested, waiting is on and ready/busy is low. Otherwise IDLE goes to GAP when a latch-to-read delay applies, and to SETUP in all other cases. RBWAIT moves to GAP or SETUP on the same rule once ready/busy goes high. GAP, SETUP, STROBE and HOLD each count down their length and then move to the next state. HIZ counts down and returns to IDLE. While the bank is inactive, window accesses complete at once in IDLE.

Top module: `nand_bank_seq`

## Requirements
- R1: After reset every register reads zero, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle` and `nand_ale` are low, and the data bus is not driven (`nand_dq_oe` low, `nand_dq_out` zero).
- R2: With `cpu_win` low, `cpu_addr[3:2]` selects a register: 0 control, 1 status, 2 write timing, 3 read timing. `cpu_ready` is high in the same cycle as the request. The control word keeps only bits 0-4, 6, 7, 12:9 and 16:13, and its other bits read zero. Status reads zero and ignores writes. Both timing words keep all 32 bits.
- R3: `nand_ce_n` is low exactly when control bit 2 (bank enable) is 1 and control bit 0 (soft reset) is 0. While it is high, no strobe, latch or bus drive is active.
- R4: In a window access, `cpu_addr[16]` set gives a command cycle (`nand_cle` high). Otherwise `cpu_addr[17]` set gives an address cycle (`nand_ale` high). With both bits clear the access is a data cycle. Bit 16 wins when both bits are set.
- R5: A cycle runs SETUP, STROBE, HOLD and HIZ for timing-word bits 7:0, 15:8, 23:16 and 31:24 clocks respectively. A field of zero gives one clock. Writes take the write-timing word and reads take the read-timing word.
- R6: The latch strobe is high through SETUP, STROBE and HOLD. `nand_we_n` (writes) or `nand_re_n` (reads) is low only during STROBE. A write drives the data bus from SETUP through HOLD and releases it in HIZ. A read never drives the bus.
- R7: Control bit 4 set selects 16-bit mode: writes drive `cpu_wdata[15:0]` and reads return `nand_dq_in[15:0]`. Bit 4 clear selects 8-bit mode: writes drive `cpu_wdata[7:0]` with the upper byte zero, and reads return `nand_dq_in[7:0]` zero-extended. Read data is sampled in the last STROBE clock.
- R8: A window access on an active bank raises `cpu_ready` in the final HIZ clock, and `cpu_rdata` then carries the read result.
- R9: When control bit 1 is set and `nand_rb` is low at the request, the cycle waits in RBWAIT with chip enable low, all strobes idle and `cpu_ready` low. It leaves RBWAIT in the clock after `nand_rb` returns high. With bit 1 clear, `nand_rb` has no effect.
- R10: A data read whose previous active cycle was a command cycle first spends control bits 12:9 clocks in GAP. If the previous cycle was an address cycle, it spends bits 16:13 clocks. Writes and other cycles never enter GAP. After reset the previous cycle counts as a data cycle.
- R11: A window access while the bank is inactive completes with `cpu_ready` in the request cycle. It toggles no flash pin and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_win | input | 1 | 1 = flash window, 0 = register file |
| cpu_addr | input | ADDR_W (18) | Register index in bits 3:2, cycle type in bits 17:16 |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Access complete |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DQ_W (16) | Data driven toward the flash |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | DQ_W (16) | Data returned from the flash |
| nand_rb | input | 1 | Ready/busy, low = busy |

## Verification
On every clock the assertions check the pin rules that hold in any state: the two latch strobes are never high together, the write and read strobes are never low together, a high chip enable silences every strobe, and the bus is driven during a write strobe and never during a read strobe. Phase lengths, the order of phases, the choice of timing word, the latch-to-read gap, the ready/busy stall and the width handling depend on register contents and on earlier cycles. Only the bench scenarios can show these, by comparing the pins every clock against a model built from the programmed values.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    localparam int REG_W = 32;
    localparam int PH_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RBWAIT,
        ST_GAP,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_HIZ
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_DATA,
        KIND_CMD,
        KIND_ADDR
    } cyc_kind_e;

    typedef struct packed {
        logic [PH_W-1:0] hiz;
        logic [PH_W-1:0] hold;
        logic [PH_W-1:0] strobe;
        logic [PH_W-1:0] setup;
    } phase_times_t;

    localparam logic [1:0] IDX_CTRL   = 2'd0;
    localparam logic [1:0] IDX_STATUS = 2'd1;
    localparam logic [1:0] IDX_TWR    = 2'd2;
    localparam logic [1:0] IDX_TRD    = 2'd3;

endpackage

// File: rtl/nbs_regs.sv
module nbs_regs
    import nbs_pkg::*;
#(
    parameter int GAP_W   = 4,
    parameter int CMD_LSB = 9,
    parameter int ADR_LSB = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       idx,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             soft_rst,
    output logic             wait_en,
    output logic             bank_en,
    output logic             wide,
    output logic [GAP_W-1:0] gap_cmd,
    output logic [GAP_W-1:0] gap_addr,
    output phase_times_t     t_wr,
    output phase_times_t     t_rd
);

    localparam logic [REG_W-1:0] GAP_ONES  = {{(REG_W-GAP_W){1'b0}}, {GAP_W{1'b1}}};
    localparam logic [REG_W-1:0] LOW_BITS  = 32'h0000_00DF;
    localparam logic [REG_W-1:0] CTRL_MASK = LOW_BITS | (GAP_ONES << CMD_LSB) | (GAP_ONES << ADR_LSB);

    logic [REG_W-1:0] ctrl_q;
    phase_times_t     twr_q;
    phase_times_t     trd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            twr_q  <= '0;
            trd_q  <= '0;
        end else if (wr_en) begin
            unique case (idx)
                IDX_CTRL:   ctrl_q <= wdata & CTRL_MASK;
                IDX_STATUS: ;
                IDX_TWR:    twr_q  <= wdata;
                IDX_TRD:    trd_q  <= wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            IDX_CTRL:   rdata = ctrl_q;
            IDX_STATUS: rdata = '0;
            IDX_TWR:    rdata = twr_q;
            IDX_TRD:    rdata = trd_q;
            default:    rdata = '0;
        endcase
    end

    assign soft_rst = ctrl_q[0];
    assign wait_en  = ctrl_q[1];
    assign bank_en  = ctrl_q[2];
    assign wide     = ctrl_q[4];
    assign gap_cmd  = ctrl_q[CMD_LSB +: GAP_W];
    assign gap_addr = ctrl_q[ADR_LSB +: GAP_W];
    assign t_wr     = twr_q;
    assign t_rd     = trd_q;

endmodule

// File: rtl/nbs_fsm.sv
module nbs_fsm
    import nbs_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             req_write,
    input  cyc_kind_e        req_kind,
    input  logic [DQ_W-1:0]  req_data,
    input  logic             active,
    input  logic             wait_en,
    input  logic             wide,
    input  logic             rb,
    input  logic [GAP_W-1:0] gap_cmd,
    input  logic [GAP_W-1:0] gap_addr,
    input  phase_times_t     t_wr,
    input  phase_times_t     t_rd,
    input  logic [DQ_W-1:0]  dq_in,
    output logic             idle,
    output logic             done,
    output logic [DQ_W-1:0]  rd_word,
    output logic             ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic             dq_oe,
    output logic [DQ_W-1:0]  dq_out
);

    localparam int HALF = DQ_W / 2;

    seq_state_e      state_q, state_d;
    logic [PH_W-1:0] cnt_q, cnt_d;
    logic            wr_q;
    cyc_kind_e       kind_q;
    cyc_kind_e       prev_q;
    logic [DQ_W-1:0] data_q;

    logic            sel_wr;
    cyc_kind_e       sel_kind;
    phase_times_t    sel_t;
    logic            need_gap;
    logic [PH_W-1:0] gap_load;
    logic            on_bus;

    function automatic logic [PH_W-1:0] span(input logic [PH_W-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

    // Attributes of the cycle being decided: live inputs in IDLE, latched afterwards
    always_comb begin
        sel_wr   = (state_q == ST_IDLE) ? req_write : wr_q;
        sel_kind = (state_q == ST_IDLE) ? req_kind  : kind_q;
        sel_t    = sel_wr ? t_wr : t_rd;
        need_gap = 1'b0;
        gap_load = '0;
        if (!sel_wr && sel_kind == KIND_DATA) begin
            if (prev_q == KIND_CMD && gap_cmd != '0) begin
                need_gap = 1'b1;
                gap_load = PH_W'(gap_cmd) - 1'b1;
            end else if (prev_q == KIND_ADDR && gap_addr != '0) begin
                need_gap = 1'b1;
                gap_load = PH_W'(gap_addr) - 1'b1;
            end
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (wait_en && !rb) begin
                        state_d = ST_RBWAIT;
                    end else if (need_gap) begin
                        state_d = ST_GAP;
                        cnt_d   = gap_load;
                    end else begin
                        state_d = ST_SETUP;
                        cnt_d   = span(sel_t.setup);
                    end
                end
            end
            ST_RBWAIT: begin
                if (rb) begin
                    if (need_gap) begin
                        state_d = ST_GAP;
                        cnt_d   = gap_load;
                    end else begin
                        state_d = ST_SETUP;
                        cnt_d   = span(sel_t.setup);
                    end
                end
            end
            ST_GAP: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    state_d = ST_SETUP;
                    cnt_d   = span(sel_t.setup);
                end
            end
            ST_SETUP: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    state_d = ST_STROBE;
                    cnt_d   = span(sel_t.strobe);
                end
            end
            ST_STROBE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    state_d = ST_HOLD;
                    cnt_d   = span(sel_t.hold);
                end
            end
            ST_HOLD: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    state_d = ST_HIZ;
                    cnt_d   = span(sel_t.hiz);
                end
            end
            ST_HIZ: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register and the per-cycle latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            kind_q  <= KIND_DATA;
            prev_q  <= KIND_DATA;
            data_q  <= '0;
            rd_word <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_IDLE && start) begin
                wr_q   <= req_write;
                kind_q <= req_kind;
                data_q <= wide ? req_data : {{(DQ_W-HALF){1'b0}}, req_data[HALF-1:0]};
            end
            if (state_q == ST_STROBE && cnt_q == '0 && !wr_q) begin
                rd_word <= wide ? dq_in : {{(DQ_W-HALF){1'b0}}, dq_in[HALF-1:0]};
            end
            if (state_q == ST_HIZ && cnt_q == '0) begin
                prev_q <= kind_q;
            end
        end
    end

    // Pin outputs
    always_comb begin
        on_bus = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        ce_n   = !active;
        cle    = on_bus && (kind_q == KIND_CMD);
        ale    = on_bus && (kind_q == KIND_ADDR);
        we_n   = !((state_q == ST_STROBE) && wr_q);
        re_n   = !((state_q == ST_STROBE) && !wr_q);
        dq_oe  = on_bus && wr_q;
        dq_out = dq_oe ? data_q : '0;
        idle   = (state_q == ST_IDLE);
        done   = (state_q == ST_HIZ) && (cnt_q == '0);
    end

endmodule

// File: rtl/nand_bank_seq.sv
module nand_bank_seq
    import nbs_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int CLE_BIT = 16,
    parameter int ALE_BIT = 17,
    parameter int DQ_W    = 16,
    parameter int GAP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_win,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    output logic              cpu_ready,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DQ_W-1:0]   nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DQ_W-1:0]   nand_dq_in,
    input  logic              nand_rb
);

    localparam int PAD_W = REG_W - DQ_W;

    logic             soft_rst, wait_en, bank_en, wide;
    logic [GAP_W-1:0] gap_cmd, gap_addr;
    phase_times_t     t_wr, t_rd;
    logic [REG_W-1:0] reg_rdata;
    logic             active, seq_idle, seq_done, reg_wr, start;
    cyc_kind_e        win_kind;
    logic [DQ_W-1:0]  rd_word;

    assign active   = bank_en && !soft_rst;
    assign win_kind = cpu_addr[CLE_BIT] ? KIND_CMD :
                      (cpu_addr[ALE_BIT] ? KIND_ADDR : KIND_DATA);
    assign reg_wr   = cpu_req && !cpu_win && cpu_we && seq_idle;
    assign start    = cpu_req && cpu_win && active && seq_idle;

    nbs_regs #(
        .GAP_W (GAP_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .idx      (cpu_addr[3:2]),
        .wdata    (cpu_wdata),
        .rdata    (reg_rdata),
        .soft_rst (soft_rst),
        .wait_en  (wait_en),
        .bank_en  (bank_en),
        .wide     (wide),
        .gap_cmd  (gap_cmd),
        .gap_addr (gap_addr),
        .t_wr     (t_wr),
        .t_rd     (t_rd)
    );

    nbs_fsm #(
        .DQ_W  (DQ_W),
        .GAP_W (GAP_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_write (cpu_we),
        .req_kind  (win_kind),
        .req_data  (cpu_wdata[DQ_W-1:0]),
        .active    (active),
        .wait_en   (wait_en),
        .wide      (wide),
        .rb        (nand_rb),
        .gap_cmd   (gap_cmd),
        .gap_addr  (gap_addr),
        .t_wr      (t_wr),
        .t_rd      (t_rd),
        .dq_in     (nand_dq_in),
        .idle      (seq_idle),
        .done      (seq_done),
        .rd_word   (rd_word),
        .ce_n      (nand_ce_n),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .dq_oe     (nand_dq_oe),
        .dq_out    (nand_dq_out)
    );

    always_comb begin
        cpu_ready = seq_done || (cpu_req && seq_idle && (!cpu_win || !active));
        if (!cpu_win)
            cpu_rdata = reg_rdata;
        else if (seq_done)
            cpu_rdata = {{PAD_W{1'b0}}, rd_word};
        else
            cpu_rdata = '0;
    end

endmodule

// File: rtl/nbs_chk.sv
module nbs_chk (
    input logic clk,
    input logic rst_n,
    input logic nand_ce_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_dq_oe
);

    // R4
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R3
    ce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ce_n |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe));

    // R6
    we_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe);

    // R6
    re_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

endmodule

bind nand_bank_seq nbs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_bank_seq_tb.sv
`timescale 1ns/1ps
module nand_bank_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic        cpu_win = 1'b0;
    logic [17:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_out;
    logic [15:0] nand_dq_in = 16'h5AC3;
    logic        nand_rb = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;

    // behavioural shadow of programmed state
    logic [31:0] ctrl_s = '0;
    logic [31:0] tw_s = '0;
    logic [31:0] tr_s = '0;
    int          prev_s = 0;
    logic [21:0] exp_q[$];

    always #4 clk = ~clk;

    nand_bank_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_win(cpu_win),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    function automatic logic [21:0] mk(bit ce_n, bit cl, bit al, bit we_n, bit re_n, bit oe, logic [15:0] dq);
        return {ce_n, cl, al, we_n, re_n, oe, dq};
    endfunction

    function automatic int max1(logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_n(input logic [21:0] v, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(v);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // per-clock pin comparison against the model (R3 R4 R5 R6 R7 R9 R10)
    always begin
        logic [21:0] e, a;
        @(posedge clk);
        #2;
        if (mon_on) begin
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else e = mk(!(ctrl_s[2] && !ctrl_s[0]), 0, 0, 1, 1, 0, 16'h0);
            a = {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_dq_out};
            n_chk++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL R6 pins actual=%h expected=%h", a, e);
            end
        end
    end

    task automatic reg_wr(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        cpu_win = 0; cpu_we = 1; cpu_addr = {14'b0, idx, 2'b00}; cpu_wdata = d; cpu_req = 1;
        #1;
        chk(cpu_ready === 1'b1, "R2 reg write ready", {31'b0, cpu_ready}, 32'd1);
        @(posedge clk);
        #1;
        cpu_req = 0;
        if (idx == 2'd0) ctrl_s = d & 32'h0001_FEDF;
        if (idx == 2'd2) tw_s = d;
        if (idx == 2'd3) tr_s = d;
    endtask

    task automatic reg_rd(input logic [1:0] idx, output logic [31:0] d);
        @(negedge clk);
        cpu_win = 0; cpu_we = 0; cpu_addr = {14'b0, idx, 2'b00}; cpu_req = 1;
        #1;
        chk(cpu_ready === 1'b1, "R2 reg read ready", {31'b0, cpu_ready}, 32'd1);
        d = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 0;
    endtask

    task automatic win_op(input bit wr, input logic [17:0] a, input logic [31:0] wd,
                          input int stall, output logic [31:0] rd);
        int kind, g, total, w;
        logic [31:0] t;
        logic [15:0] dv;
        bit act, cl, al;
        act  = ctrl_s[2] && !ctrl_s[0];
        kind = a[16] ? 1 : (a[17] ? 2 : 0);
        cl   = (kind == 1);
        al   = (kind == 2);
        t    = wr ? tw_s : tr_s;
        dv   = ctrl_s[4] ? wd[15:0] : {8'h00, wd[7:0]};
        total = 0;
        @(negedge clk);
        if (stall > 0) nand_rb = 1'b0;
        cpu_win = 1; cpu_we = wr; cpu_addr = a; cpu_wdata = wd; cpu_req = 1;
        if (act) begin
            if (ctrl_s[1] && stall > 0) begin
                push_n(mk(0, 0, 0, 1, 1, 0, 16'h0), stall);
                total += stall;
            end
            g = 0;
            if (!wr && kind == 0) begin
                if (prev_s == 1) g = int'(ctrl_s[12:9]);
                else if (prev_s == 2) g = int'(ctrl_s[16:13]);
            end
            push_n(mk(0, 0, 0, 1, 1, 0, 16'h0), g);
            total += g;
            push_n(mk(0, cl, al, 1, 1, wr, wr ? dv : 16'h0), max1(t[7:0]));
            push_n(mk(0, cl, al, !wr, wr, wr, wr ? dv : 16'h0), max1(t[15:8]));
            push_n(mk(0, cl, al, 1, 1, wr, wr ? dv : 16'h0), max1(t[23:16]));
            push_n(mk(0, 0, 0, 1, 1, 0, 16'h0), max1(t[31:24]));
            total += max1(t[7:0]) + max1(t[15:8]) + max1(t[23:16]) + max1(t[31:24]);
            prev_s = kind;
        end
        w = 0;
        #1;
        while (!cpu_ready && w < 1000) begin
            @(negedge clk);
            w++;
            if (stall > 0 && w == stall) nand_rb = 1'b1;
            #1;
        end
        nand_rb = 1'b1;
        chk(w == total, "R8 ready clock", w, total);
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 0; cpu_win = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        mon_on = 1;
        #1;
        // R1 reset pins and registers
        chk({nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe} === 6'b100110 && nand_dq_out === 16'h0,
            "R1 pins", {26'b0, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe}, 32'b100110);
        for (int i = 0; i < 4; i++) begin
            reg_rd(2'(i), d);
            chk(d === 32'h0, "R1 reg zero", d, 32'h0);
        end

        // R11 inactive bank: immediate completion, zero read
        win_op(1'b1, 18'h10000, 32'hAA, 0, d);
        win_op(1'b0, 18'h00000, 32'h0, 0, d);
        chk(d === 32'h0, "R11 inactive read", d, 32'h0);

        // R2 control masking, soft reset keeps bank quiet (R3)
        reg_wr(2'd0, 32'hFFFF_FFFF);
        reg_rd(2'd0, d);
        chk(d === 32'h0001_FEDF, "R2 ctrl mask", d, 32'h0001_FEDF);
        chk(nand_ce_n === 1'b1, "R3 soft reset holds ce", {31'b0, nand_ce_n}, 32'd1);
        win_op(1'b1, 18'h00000, 32'h55, 0, d);
        reg_wr(2'd1, 32'hFFFF_FFFF);
        reg_rd(2'd1, d);
        chk(d === 32'h0, "R2 status zero", d, 32'h0);
        reg_wr(2'd3, 32'hDEAD_BEEF);
        reg_rd(2'd3, d);
        chk(d === 32'hDEAD_BEEF, "R2 read timing word", d, 32'hDEAD_BEEF);

        // R3 R4 R5 R6 R7: 8-bit writes of each kind
        reg_wr(2'd0, 32'h0000_0004);
        chk(nand_ce_n === 1'b0, "R3 enable drives ce", {31'b0, nand_ce_n}, 32'd0);
        reg_wr(2'd2, 32'h0201_0300);
        reg_rd(2'd2, d);
        chk(d === 32'h0201_0300, "R2 write timing word", d, 32'h0201_0300);
        win_op(1'b1, 18'h10000, 32'h1A5, 0, d);
        win_op(1'b1, 18'h20000, 32'h33, 0, d);
        win_op(1'b1, 18'h30000, 32'h70, 0, d);
        win_op(1'b1, 18'h00040, 32'hBEEF, 0, d);

        // R7 16-bit write
        reg_wr(2'd0, 32'h0000_0014);
        win_op(1'b1, 18'h00000, 32'h1234_BEEF, 0, d);

        // R10 gap after command and address, R5 read timing word, R7 read width
        reg_wr(2'd3, 32'h0100_0202);
        reg_wr(2'd0, 32'h0000_4614);
        win_op(1'b1, 18'h10000, 32'h30, 0, d);
        win_op(1'b0, 18'h00000, 32'h0, 0, d);
        chk(d === 32'h0000_5AC3, "R7 wide read", d, 32'h0000_5AC3);
        win_op(1'b1, 18'h20000, 32'h01, 0, d);
        win_op(1'b0, 18'h00000, 32'h0, 0, d);
        chk(d === 32'h0000_5AC3, "R10 read after address", d, 32'h0000_5AC3);
        win_op(1'b0, 18'h00000, 32'h0, 0, d);
        win_op(1'b1, 18'h10000, 32'h31, 0, d);
        win_op(1'b1, 18'h00000, 32'h4242, 0, d);
        reg_wr(2'd0, 32'h0000_4604);
        win_op(1'b1, 18'h10000, 32'h05, 0, d);
        win_op(1'b0, 18'h00000, 32'h0, 0, d);
        chk(d === 32'h0000_00C3, "R7 narrow read", d, 32'h0000_00C3);

        // R9 ready/busy stall and its bypass
        reg_wr(2'd0, 32'h0000_0006);
        win_op(1'b1, 18'h00000, 32'h99, 4, d);
        win_op(1'b0, 18'h00000, 32'h0, 3, d);
        chk(d === 32'h0000_00C3, "R9 read after stall", d, 32'h0000_00C3);
        reg_wr(2'd0, 32'h0000_0004);
        win_op(1'b1, 18'h00000, 32'h77, 3, d);

        // R5 all-zero timing gives one clock per phase
        reg_wr(2'd2, 32'h0);
        win_op(1'b1, 18'h20000, 32'hE1, 0, d);

        // R3 disable releases chip enable
        reg_wr(2'd0, 32'h0);
        chk(nand_ce_n === 1'b1, "R3 disable", {31'b0, nand_ce_n}, 32'd1);
        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end

endmodule